// File: doc/BRIEF.md
# Sector ECC Syndrome Corrector

This block checks a 512-byte flash sector against its 3-byte Hamming code. It takes the code read back from the spare area and the code recomputed over the data it just read, and forms their bitwise difference (the syndrome). It sorts the syndrome into one of four outcomes: clean, a single flipped data bit that can be repaired, damage confined to the stored code bytes, or a fault it cannot repair. For a repairable data bit it reports which byte of the sector holds the bad bit and which bit of that byte it is.

When repair is requested, the block fixes the sector in place. It reads the bad byte from an attached 512x8 buffer, flips the one faulty bit and writes the byte back. A single-cycle `done` pulse closes every operation. The code itself is produced elsewhere.

Top module: `ecc_fix_top`

## Requirements
- R1: After reset, `done`, `bufRdEn` and `bufWrEn` are low, and `status`, `errByte` and `errBit` are zero.
- R2: The syndrome is `storedEcc ^ calcEcc`. Byte k of the code is bits 8k+7..8k. A zero syndrome gives status 2'b00 and makes no buffer access. In that case `done` rises in the second cycle after the cycle in which `start` is sampled.
- R3: A syndrome is repairable only when, for every k from 0 to 11, syndrome bit 2k+1 differs from bit 2k. Such a syndrome gives status 2'b01.
- R4: For a repairable syndrome, `errByte` bit i equals syndrome bit 2i for i = 0..8. This puts code byte 0 in address bits 3..0, byte 1 in bits 7..4 and byte 2 bit 0 in bit 8.
- R5: For a repairable syndrome, `errBit` bit j equals syndrome bit 18+2j for j = 0..2. For any other status, `errByte` and `errBit` read zero.
- R6: With `fixEn` high at start, a repairable error runs a read-modify-write. `bufRdEn` is high for one cycle with `bufAddr` = `errByte`. In the next cycle `bufWrEn` is high and `bufWrData` equals the byte read with only bit `errBit` inverted. `done` follows one cycle later.
- R7: A syndrome with exactly one bit set gives status 2'b10. The buffer is not accessed.
- R8: Any other non-zero syndrome gives status 2'b11. The buffer is not accessed.
- R9: With `fixEn` low at start, a repairable error is still reported with its location, but the buffer is neither read nor written.
- R10: `start` is ignored while an operation is in progress.
- R11: `done` is high for exactly one cycle per operation. `status`, `errByte` and `errBit` hold their values until the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a check; sampled only when idle |
| fixEn | input | 1 | Repair the buffer for a repairable error |
| storedEcc | input | 24 | Code read from flash, byte 0 in bits 7..0 |
| calcEcc | input | 24 | Code recomputed over the sector |
| bufRdData | input | 8 | Buffer read data, valid the cycle after `bufRdEn` |
| bufAddr | output | 9 | Buffer byte address |
| bufRdEn | output | 1 | Buffer read strobe |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrData | output | 8 | Corrected byte |
| status | output | 2 | 00 clean, 01 data repaired, 10 code-byte error, 11 uncorrectable |
| errByte | output | 9 | Faulty byte address |
| errBit | output | 3 | Faulty bit index |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- every write follows a read of the same address;
- a written byte differs from the byte read in exactly one bit;
- writes happen only under status 01;
- `done` follows a write and never lasts two cycles.

Some behaviours only the bench scenarios can show:
- that the syndrome-to-address and syndrome-to-bit maps are correct;
- that the four classes are separated correctly, including near-miss patterns with one pair equal;
- that `fixEn` low suppresses the access;
- that a mid-operation `start` is dropped.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_DATA   = 2'b01,
    ST_ECCERR = 2'b10,
    ST_UNCORR = 2'b11
  } status_e;

  typedef struct packed {
    logic loadSyn;
    logic latchRes;
    logic rdStb;
    logic wrStb;
    logic doneStb;
  } ctl_t;

endpackage

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
  import ecc_fix_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic needWrite,
  output ctl_t ctl
);

  typedef enum logic [2:0] {S_IDLE, S_CLASS, S_READ, S_WRITE, S_FIN} state_e;
  state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE:  if (start) stateD = S_CLASS;
      S_CLASS: stateD = needWrite ? S_READ : S_FIN;
      S_READ:  stateD = S_WRITE;
      S_WRITE: stateD = S_FIN;
      S_FIN:   stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctl          = '0;
    ctl.loadSyn  = (stateQ == S_IDLE) && start;
    ctl.latchRes = (stateQ == S_CLASS);
    ctl.rdStb    = (stateQ == S_READ);
    ctl.wrStb    = (stateQ == S_WRITE);
    ctl.doneStb  = (stateQ == S_FIN);
  end

  // R10: a start while busy never reloads the syndrome
  assert_no_reload_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_IDLE) |-> !ctl.loadSyn);

endmodule

// File: rtl/ecc_fix_dp.sv
module ecc_fix_dp
  import ecc_fix_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_t                  ctl,
  input  logic                  fixEn,
  input  logic [SYN_W-1:0]      storedEcc,
  input  logic [SYN_W-1:0]      calcEcc,
  input  logic [DATA_W-1:0]     bufRdData,
  output logic                  needWrite,
  output logic [1:0]            status,
  output logic [ADDR_W-1:0]     errByte,
  output logic [BIT_W-1:0]      errBit,
  output logic [DATA_W-1:0]     bufWrData
);

  localparam int PAIRS  = ADDR_W + BIT_W;
  localparam int SYN_W  = 2 * PAIRS;
  localparam int DATA_W = 1 << BIT_W;

  logic [SYN_W-1:0]  synQ;
  logic              fixQ;
  logic [PAIRS-1:0]  pairDiff;
  logic [ADDR_W-1:0] locByte;
  logic [BIT_W-1:0]  locBit;
  status_e           clsD;
  status_e           statusQ;
  logic [ADDR_W-1:0] byteQ;
  logic [BIT_W-1:0]  bitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      synQ <= '0;
      fixQ <= 1'b0;
    end else if (ctl.loadSyn) begin
      synQ <= storedEcc ^ calcEcc;
      fixQ <= fixEn;
    end
  end

  for (genvar p = 0; p < PAIRS; p++) begin : gPair
    assign pairDiff[p] = synQ[2*p+1] ^ synQ[2*p];
  end
  for (genvar i = 0; i < ADDR_W; i++) begin : gByte
    assign locByte[i] = synQ[2*i];
  end
  for (genvar j = 0; j < BIT_W; j++) begin : gBit
    assign locBit[j] = synQ[2*(ADDR_W+j)];
  end

  always_comb begin
    if (synQ == '0)                clsD = ST_CLEAN;
    else if (&pairDiff)            clsD = ST_DATA;
    else if ($countones(synQ) == 1) clsD = ST_ECCERR;
    else                           clsD = ST_UNCORR;
  end

  assign needWrite = (clsD == ST_DATA) && fixQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= ST_CLEAN;
      byteQ   <= '0;
      bitQ    <= '0;
    end else if (ctl.latchRes) begin
      statusQ <= clsD;
      byteQ   <= (clsD == ST_DATA) ? locByte : '0;
      bitQ    <= (clsD == ST_DATA) ? locBit  : '0;
    end
  end

  assign status    = statusQ;
  assign errByte   = byteQ;
  assign errBit    = bitQ;
  assign bufWrData = bufRdData ^ (DATA_W'(1) << bitQ);

  // R5: location fields stay zero whenever the latched class is not a data error
  assert_loc_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (status != 2'b01) |-> (errByte == '0 && errBit == '0));

endmodule

// File: rtl/ecc_fix_top.sv
module ecc_fix_top
  import ecc_fix_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3,
  localparam int SYN_W  = 2 * (ADDR_W + BIT_W),
  localparam int DATA_W = 1 << BIT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              fixEn,
  input  logic [SYN_W-1:0]  storedEcc,
  input  logic [SYN_W-1:0]  calcEcc,
  input  logic [DATA_W-1:0] bufRdData,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              bufRdEn,
  output logic              bufWrEn,
  output logic [DATA_W-1:0] bufWrData,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] errByte,
  output logic [BIT_W-1:0]  errBit,
  output logic              done
);

  ctl_t ctl;
  logic needWrite;

  ecc_fix_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .needWrite (needWrite),
    .ctl       (ctl)
  );

  ecc_fix_dp #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .fixEn     (fixEn),
    .storedEcc (storedEcc),
    .calcEcc   (calcEcc),
    .bufRdData (bufRdData),
    .needWrite (needWrite),
    .status    (status),
    .errByte   (errByte),
    .errBit    (errBit),
    .bufWrData (bufWrData)
  );

  assign bufAddr = errByte;
  assign bufRdEn = ctl.rdStb;
  assign bufWrEn = ctl.wrStb;
  assign done    = ctl.doneStb;

  assert_wr_after_rd_R6: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> ($past(bufRdEn) && $stable(bufAddr)));

  assert_one_bit_flip_R6: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> ($countones(bufWrData ^ bufRdData) == 1));

  assert_done_after_wr_R6: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |=> done);

  // R7, R8: only a repairable data error may touch the buffer
  assert_wr_only_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrEn || bufRdEn) |-> (status == 2'b01));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_strobes_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({bufRdEn, bufWrEn, done}) <= 1);

endmodule

// File: tb/tb_ecc_fix_top.sv
`timescale 1ns/1ps
module tb_ecc_fix_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        fixEn = 1'b0;
  logic [23:0] storedEcc = '0;
  logic [23:0] calcEcc = '0;
  logic [7:0]  bufRdData;
  logic [8:0]  bufAddr;
  logic        bufRdEn, bufWrEn;
  logic [7:0]  bufWrData;
  logic [1:0]  status;
  logic [8:0]  errByte;
  logic [2:0]  errBit;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [512];

  always #2 clk = ~clk;

  ecc_fix_top dut (
    .clk(clk), .rstN(rstN), .start(start), .fixEn(fixEn),
    .storedEcc(storedEcc), .calcEcc(calcEcc), .bufRdData(bufRdData),
    .bufAddr(bufAddr), .bufRdEn(bufRdEn), .bufWrEn(bufWrEn),
    .bufWrData(bufWrData), .status(status), .errByte(errByte),
    .errBit(errBit), .done(done)
  );

  initial begin
    bufRdData = '0;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 5);
  end

  always @(posedge clk) begin
    if (bufRdEn) bufRdData <= mem[bufAddr];
    if (bufWrEn) mem[bufAddr] <= bufWrData;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // build a repairable syndrome from a location
  function automatic logic [23:0] mkSyn(input int addr, input int bitIdx);
    logic [23:0] s;
    for (int i = 0; i < 9; i++) begin
      s[2*i]   = addr[i];
      s[2*i+1] = ~addr[i];
    end
    for (int j = 0; j < 3; j++) begin
      s[18+2*j] = bitIdx[j];
      s[19+2*j] = ~bitIdx[j];
    end
    return s;
  endfunction

  task automatic runOp(input logic [23:0] st, input logic [23:0] ca,
                       input bit fix, input bit poke);
    logic [23:0] s;
    bit repair;
    int ones, expSt, expByte, expBit, nDone;
    bit needW;
    logic [7:0] orig;
    s = st ^ ca;
    repair = 1;
    ones = 0;
    for (int k = 0; k < 12; k++) if (s[2*k+1] == s[2*k]) repair = 0;
    for (int k = 0; k < 24; k++) if (s[k]) ones++;
    expByte = 0;
    expBit = 0;
    if (s == 0) expSt = 0;
    else if (repair) begin
      expSt = 1;
      for (int i = 0; i < 9; i++) expByte |= int'(s[2*i]) << i;
      for (int j = 0; j < 3; j++) expBit |= int'(s[18+2*j]) << j;
    end
    else if (ones == 1) expSt = 2;
    else expSt = 3;
    needW = (expSt == 1) && fix;
    nDone = needW ? 4 : 2;
    orig = mem[expByte];

    @(negedge clk);
    storedEcc = st; calcEcc = ca; fixEn = fix; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      start = 1'b1; storedEcc = 24'h000001; calcEcc = 24'h000000; fixEn = 1'b1;
    end
    check(!done && !bufRdEn && !bufWrEn, "R2 idle strobes in classify cycle",
          {29'd0, done, bufRdEn, bufWrEn}, 0);
    for (int c = 2; c <= nDone + 3; c++) begin
      @(negedge clk);
      start = 1'b0;
      check(bufRdEn == (needW && c == 2), needW ? "R6 read strobe" : "R9 no buffer read",
            32'(bufRdEn), 32'(needW && c == 2));
      check(bufWrEn == (needW && c == 3), needW ? "R6 write strobe" : "R7 R8 no buffer write",
            32'(bufWrEn), 32'(needW && c == 3));
      check(done == (c == nDone), (c > nDone) ? "R10 R11 no extra done" : "R2 R11 done timing",
            32'(done), 32'(c == nDone));
      if (needW && c == 2)
        check(bufAddr == 9'(expByte), "R6 read address", 32'(bufAddr), 32'(expByte));
      if (needW && c == 3)
        check(bufWrData == (orig ^ (8'd1 << expBit)), "R6 corrected byte",
              32'(bufWrData), 32'(orig ^ (8'd1 << expBit)));
      if (c == nDone) begin
        check(status == 2'(expSt), "R3 R7 R8 status", 32'(status), 32'(expSt));
        check(errByte == 9'(expByte), "R4 byte address", 32'(errByte), 32'(expByte));
        check(errBit == 3'(expBit), "R5 bit index", 32'(errBit), 32'(expBit));
      end
      if (c == nDone + 3)
        check(status == 2'(expSt), "R11 status held", 32'(status), 32'(expSt));
    end
    if (needW)
      check(mem[expByte] == (orig ^ (8'd1 << expBit)), "R6 buffer repaired",
            32'(mem[expByte]), 32'(orig ^ (8'd1 << expBit)));
    else
      check(mem[expByte] == orig, "R9 buffer untouched", 32'(mem[expByte]), 32'(orig));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !bufRdEn && !bufWrEn, "R1 reset strobes", {29'd0, done, bufRdEn, bufWrEn}, 0);
    check(status == 0 && errByte == 0 && errBit == 0, "R1 reset outputs",
          {18'd0, status, errByte, errBit}, 0);

    runOp(24'h5A3C91, 24'h5A3C91, 1'b1, 1'b0);              // R2 clean
    runOp(24'h123456, 24'h123456 ^ mkSyn(0, 0), 1'b1, 1'b0);   // R3 R6
    runOp(24'hABCDEF, 24'hABCDEF ^ mkSyn(511, 7), 1'b1, 1'b0); // R4 R5 edges
    runOp(24'h0F0F0F, 24'h0F0F0F ^ mkSyn(301, 5), 1'b1, 1'b0);
    runOp(24'h777777, 24'h777777 ^ mkSyn(166, 2), 1'b0, 1'b0); // R9
    runOp(24'h000000, 24'h002000, 1'b1, 1'b0);              // R7
    runOp(24'h800000, 24'h000000, 1'b1, 1'b0);              // R7
    runOp(24'h000003, 24'h000000, 1'b1, 1'b0);              // R8
    runOp(24'hFFFFFF, 24'h000000, 1'b1, 1'b0);              // R8
    runOp(24'h000000, mkSyn(85, 3) & 24'hFFF3FF, 1'b1, 1'b0); // R8 one pair equal
    runOp(24'h3C3C3C, 24'h3C3C3C ^ mkSyn(42, 6), 1'b1, 1'b1); // R10 busy start
    runOp(24'h3C3C3C, 24'h3C3C3C ^ mkSyn(42, 6), 1'b1, 1'b0); // repair back

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule